// File: doc/BRIEF.md
# DRAM In-Array Row Copy Sequencer

This block drives the control pins of an asynchronous DRAM with a multiplexed address bus so that one full row is copied onto another inside the array, with no data passing through the pins. It opens the source row so that the sense amplifiers restore it onto the bitlines. It then moves the address bus to the target row and raises the row strobe for only a short time, much shorter than the precharge time. Because the bitlines are never precharged, the still-latched source data dominates when the target row opens, and the sense amplifiers write it into the target cells.

A single-cycle start request with a source and a target row address begins a copy. The block raises busy for the whole sequence and pulses done once at the end. Every interval is a parameter counted in clock cycles. Column strobe and write enable stay inactive, so the part stays in read mode throughout. With the default intervals and a 250 MHz clock, a copy takes 110 cycles (about 440 ns).

Top module: `dram_row_copy_seq`

## Requirements
- R1: `casN` and `weN` are 1 in every cycle: after reset, while idle and during the whole copy.
- R2: A start accepted on an edge while `busy` is 0 makes `busy` 1 from the next cycle. `rowAddr` then shows the source row and `rasN` stays 1 for `T_PRE` cycles.
- R3: Next, `rasN` goes to 0 for `T_RCD` cycles while `rowAddr` still shows the source row.
- R4: Next, `rowAddr` changes to the target row and `rasN` stays 0 for `T_SETTLE` more cycles.
- R5: Next, `rasN` goes to 1 for exactly `T_GLITCH` cycles (a minimum of 1) and then returns to 0.
- R6: `rasN` then stays 0 for `T_ACT` cycles and then goes to 1 for `T_PRE` cycles, with `rowAddr` on the target row and `busy` at 1 throughout.
- R7: Let L = 2*T_PRE + T_RCD + T_SETTLE + T_GLITCH + T_ACT. In cycle L after the start edge, `done` is 1 for exactly one cycle and `busy` is 0 in that same cycle.
- R8: A start request while `busy` is 1 has no effect: the timing of `rasN`, `rowAddr`, `busy` and `done` does not change.
- R9: After reset, `rasN` is 1, `busy` and `done` are 0 and `rowAddr` is 0. When idle, `rasN` is 1 and `rowAddr` keeps the last target row, whatever the inputs do.
- R10: When the source row equals the target row, the full sequence of R2 to R7 still runs.
- R11: A start presented in the cycle where `done` is 1 is accepted, because `busy` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Start request, taken when not busy |
| srcRow | input | ROW_W | Source row, captured at start |
| dstRow | input | ROW_W | Target row, captured at start |
| rowAddr | output | ROW_W | Row address bus to the DRAM |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, held inactive (1) |
| weN | output | 1 | Write enable, held at 1 (read) |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The copy is run with distinct source and target rows, with equal rows, and with the extreme rows 0x00 and 0xFF in both directions. These patterns show whether the address mux switches at the right phase boundary and whether the captured target survives later changes on the inputs. Starts held high through a whole copy, and starts pulsed inside each phase, show whether a request during busy is ignored while a request in the done cycle is accepted. The bench uses a one-cycle glitch, so a design that loses or stretches the short high phase differs from the model in the cycle-exact comparison of the row strobe.

// File: rtl/dram_row_copy_pkg.sv
`timescale 1ns/1ps
package dram_row_copy_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_PRE    = 3'd1,
    PH_RCD    = 3'd2,
    PH_SETTLE = 3'd3,
    PH_GLITCH = 3'd4,
    PH_ACT    = 3'd5,
    PH_POST   = 3'd6
  } phase_t;

  typedef struct packed {
    logic capture;
    logic toDst;
    logic rasLow;
    logic busyNext;
    logic doneNext;
  } strobe_t;

endpackage

// File: rtl/dram_row_copy_ctrl.sv
`timescale 1ns/1ps
module dram_row_copy_ctrl
  import dram_row_copy_pkg::*;
#(
  parameter int unsigned T_PRE    = 25,
  parameter int unsigned T_RCD    = 8,
  parameter int unsigned T_SETTLE = 2,
  parameter int unsigned T_GLITCH = 10,
  parameter int unsigned T_ACT    = 40
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  output strobe_t strobes
);

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned MAX_T =
    maxOf(maxOf(maxOf(T_PRE, T_RCD), maxOf(T_SETTLE, T_GLITCH)), T_ACT);
  localparam int unsigned CNT_W = (MAX_T < 2) ? 1 : $clog2(MAX_T + 1);

  phase_t           phase;
  phase_t           phaseNext;
  logic [CNT_W-1:0] cnt;
  logic             lastCycle;

  // Length in cycles of each phase; zero lengths are raised to one.
  function automatic int unsigned lenOf(input phase_t p);
    int unsigned n;
    case (p)
      PH_PRE:    n = T_PRE;
      PH_RCD:    n = T_RCD;
      PH_SETTLE: n = T_SETTLE;
      PH_GLITCH: n = T_GLITCH;
      PH_ACT:    n = T_ACT;
      PH_POST:   n = T_PRE;
      default:   n = 1;
    endcase
    return (n == 0) ? 1 : n;
  endfunction

  function automatic phase_t following(input phase_t p);
    case (p)
      PH_PRE:    return PH_RCD;
      PH_RCD:    return PH_SETTLE;
      PH_SETTLE: return PH_GLITCH;
      PH_GLITCH: return PH_ACT;
      PH_ACT:    return PH_POST;
      default:   return PH_IDLE;
    endcase
  endfunction

  assign lastCycle = (cnt == '0);

  always_comb begin
    phaseNext = phase;
    if (phase == PH_IDLE) begin
      if (startReq) phaseNext = PH_PRE;
    end else if (lastCycle) begin
      phaseNext = following(phase);
    end
  end

  always_comb begin
    strobes.capture  = (phase == PH_IDLE) && startReq;
    strobes.toDst    = (phase == PH_RCD) && lastCycle;
    strobes.rasLow   = (phaseNext == PH_RCD) || (phaseNext == PH_SETTLE) ||
                       (phaseNext == PH_ACT);
    strobes.busyNext = (phaseNext != PH_IDLE);
    strobes.doneNext = (phase == PH_POST) && lastCycle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phaseNext;
      if (phaseNext != phase) begin
        cnt <= CNT_W'(lenOf(phaseNext) - 1);
      end else if (!lastCycle) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/dram_row_copy_dp.sv
`timescale 1ns/1ps
module dram_row_copy_dp
  import dram_row_copy_pkg::*;
#(
  parameter int unsigned ROW_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [ROW_W-1:0] srcRow,
  input  logic [ROW_W-1:0] dstRow,
  output logic [ROW_W-1:0] rowAddr,
  output logic             rasN,
  output logic             casN,
  output logic             weN,
  output logic             busy,
  output logic             done
);

  logic [ROW_W-1:0] addrReg;
  logic [ROW_W-1:0] dstReg;
  logic             rasNReg;
  logic             busyReg;
  logic             doneReg;

  // The source goes straight onto the bus; the target waits in dstReg.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dstReg  <= '0;
    end else if (strobes.capture) begin
      addrReg <= srcRow;
      dstReg  <= dstRow;
    end else if (strobes.toDst) begin
      addrReg <= dstReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasNReg <= 1'b1;
      busyReg <= 1'b0;
      doneReg <= 1'b0;
    end else begin
      rasNReg <= ~strobes.rasLow;
      busyReg <= strobes.busyNext;
      doneReg <= strobes.doneNext;
    end
  end

  assign rowAddr = addrReg;
  assign rasN    = rasNReg;
  assign casN    = 1'b1;
  assign weN     = 1'b1;
  assign busy    = busyReg;
  assign done    = doneReg;

endmodule

// File: rtl/dram_row_copy_seq.sv
`timescale 1ns/1ps
module dram_row_copy_seq
  import dram_row_copy_pkg::*;
#(
  parameter int unsigned ROW_W    = 8,
  parameter int unsigned T_PRE    = 25,
  parameter int unsigned T_RCD    = 8,
  parameter int unsigned T_SETTLE = 2,
  parameter int unsigned T_GLITCH = 10,
  parameter int unsigned T_ACT    = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [ROW_W-1:0] srcRow,
  input  logic [ROW_W-1:0] dstRow,
  output logic [ROW_W-1:0] rowAddr,
  output logic             rasN,
  output logic             casN,
  output logic             weN,
  output logic             busy,
  output logic             done
);

  strobe_t strobes;

  dram_row_copy_ctrl #(
    .T_PRE    (T_PRE),
    .T_RCD    (T_RCD),
    .T_SETTLE (T_SETTLE),
    .T_GLITCH (T_GLITCH),
    .T_ACT    (T_ACT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .strobes  (strobes)
  );

  dram_row_copy_dp #(
    .ROW_W (ROW_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .srcRow  (srcRow),
    .dstRow  (dstRow),
    .rowAddr (rowAddr),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN),
    .busy    (busy),
    .done    (done)
  );

endmodule

// File: rtl/dram_row_copy_chk.sv
`timescale 1ns/1ps
module dram_row_copy_chk #(
  parameter int unsigned ROW_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic [ROW_W-1:0] rowAddr,
  input logic             rasN,
  input logic             busy,
  input logic             done
);

  logic seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> busy);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    (seen && done) |-> (!busy && $past(busy)));

  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> (busy || done));

  a_r9_idle_ras_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> rasN);

  a_r9_idle_addr_holds: assert property (@(posedge clk) disable iff (!rstN)
    (seen && !busy && !$past(busy)) |-> $stable(rowAddr));

endmodule

bind dram_row_copy_seq dram_row_copy_chk #(.ROW_W(ROW_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .rowAddr  (rowAddr),
  .rasN     (rasN),
  .busy     (busy),
  .done     (done)
);

// File: tb/dram_row_copy_seq_tb.sv
`timescale 1ns/1ps
module dram_row_copy_seq_tb;

  localparam int ROW_W    = 8;
  localparam int T_PRE    = 6;
  localparam int T_RCD    = 3;
  localparam int T_SETTLE = 2;
  localparam int T_GLITCH = 1;
  localparam int T_ACT    = 5;

  typedef struct {
    bit              ras;
    bit [ROW_W-1:0]  addr;
    bit              busy;
    bit              done;
    string           tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startReq = 1'b0;
  logic [ROW_W-1:0] srcRow = '0;
  logic [ROW_W-1:0] dstRow = '0;
  logic [ROW_W-1:0] rowAddr;
  logic             rasN, casN, weN, busy, done;

  int total = 0;
  int bad = 0;
  exp_t q[$];
  bit [ROW_W-1:0] lastAddr = '0;

  always #2 clk = ~clk;

  dram_row_copy_seq #(
    .ROW_W(ROW_W), .T_PRE(T_PRE), .T_RCD(T_RCD), .T_SETTLE(T_SETTLE),
    .T_GLITCH(T_GLITCH), .T_ACT(T_ACT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .srcRow(srcRow), .dstRow(dstRow),
    .rowAddr(rowAddr), .rasN(rasN), .casN(casN), .weN(weN), .busy(busy), .done(done)
  );

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end (actual hung, expected finish)");
    report();
  end

  function automatic void pushRun(input int n, input bit ras, input bit [ROW_W-1:0] a,
                                  input bit b, input bit d, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.ras = ras; e.addr = a; e.busy = b; e.done = d; e.tag = tag;
      q.push_back(e);
    end
  endfunction

  // Model of one accepted copy, cycle by cycle from the edge after the start.
  function automatic void modelCopy(input bit [ROW_W-1:0] s, input bit [ROW_W-1:0] d);
    pushRun(T_PRE,    1'b1, s, 1'b1, 1'b0, "R2");
    pushRun(T_RCD,    1'b0, s, 1'b1, 1'b0, "R3");
    pushRun(T_SETTLE, 1'b0, d, 1'b1, 1'b0, "R4");
    pushRun(T_GLITCH, 1'b1, d, 1'b1, 1'b0, "R5");
    pushRun(T_ACT,    1'b0, d, 1'b1, 1'b0, "R6");
    pushRun(T_PRE,    1'b1, d, 1'b1, 1'b0, "R6");
    pushRun(1,        1'b1, d, 1'b0, 1'b1, "R7");
    lastAddr = d;
  endfunction

  task automatic compare(input exp_t e, input string scn);
    total++;
    if (rasN !== e.ras || rowAddr !== e.addr || busy !== e.busy || done !== e.done) begin
      bad++;
      $display("FAIL %s [%s]: actual ras=%0b addr=%02h busy=%0b done=%0b expected ras=%0b addr=%02h busy=%0b done=%0b",
               e.tag, scn, rasN, rowAddr, busy, done, e.ras, e.addr, e.busy, e.done);
    end
    total++;
    if (casN !== 1'b1 || weN !== 1'b1) begin
      bad++;
      $display("FAIL R1 [%s]: actual casN=%0b weN=%0b expected casN=1 weN=1", scn, casN, weN);
    end
  endtask

  // One cycle: check this cycle at the falling edge, then drive the next edge.
  task automatic step(input bit st, input bit [ROW_W-1:0] s, input bit [ROW_W-1:0] d,
                      input string scn);
    exp_t e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else begin
      e.ras = 1'b1; e.addr = lastAddr; e.busy = 1'b0; e.done = 1'b0; e.tag = "R9";
    end
    compare(e, scn);
    startReq = st; srcRow = s; dstRow = d;
    if (st && !e.busy) modelCopy(s, d);
  endtask

  task automatic idle(input int n, input string scn);
    for (int i = 0; i < n; i++) step(1'b0, ROW_W'(i * 37 + 5), ROW_W'(i * 91 + 3), scn);
  endtask

  localparam int LEN = 2 * T_PRE + T_RCD + T_SETTLE + T_GLITCH + T_ACT;

  initial begin
    exp_t r;
    r.ras = 1'b1; r.addr = '0; r.busy = 1'b0; r.done = 1'b0; r.tag = "R9";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare(r, "reset");
    end
    rstN = 1'b1;

    idle(3, "R9 idle after reset");
    step(1'b1, 8'h3C, 8'hA5, "R2 basic copy");
    idle(LEN + 4, "R2 basic copy");
    idle(5, "R9 address holds");

    step(1'b1, 8'h77, 8'h77, "R10 same row");
    idle(LEN + 3, "R10 same row");

    step(1'b1, 8'h12, 8'hE8, "R8 busy starts");
    for (int i = 0; i < LEN + 3; i++) begin
      step(i % 2 == 0, ROW_W'(i), ROW_W'(255 - i), "R8 busy starts");
    end

    // Start held high: second copy begins in the done cycle.
    for (int i = 0; i < 2 * LEN + 2; i++) begin
      step(1'b1, (i <= LEN) ? 8'h00 : 8'hFF, (i <= LEN) ? 8'hFF : 8'h00, "R11 back to back");
    end
    step(1'b0, 8'h55, 8'hAA, "R11 back to back");
    idle(LEN + 4, "R11 back to back");

    step(1'b1, 8'hFF, 8'h00, "R4 extreme rows");
    idle(LEN + 4, "R4 extreme rows");

    report();
  end

endmodule